// File: doc/BRIEF.md
# Ownership-Handoff Shared Mailbox

This block is a 256-bit register file shared by two agents: a requester and a responder. It is split into eight 32-bit words. Each side has its own word-addressed write port and its own combinational read port. Only one side owns the mailbox at a time, and only the owner's writes land. When the owner writes the final word (word 7), ownership passes to the other side.

A request works like this. The requester fills whichever payload words it needs, then writes the header into word 7. That write hands the mailbox to the responder and raises a one-cycle pulse. The responder reads the request, writes its response header into word 7, and that write hands the mailbox back. Bit 31 of word 7 does not come from storage. It always shows the current owner, so the requester learns that the reply has arrived by polling that bit.

While the function-reset input is high, every read on the requester side returns all ones. The responder's view is not affected, and neither is the stored content.

Top module: `handoff_mailbox`

## Requirements
- R1: After reset all eight words read as zero on both sides, `ownedByRsp` is 0 and `handoffPulse` is 0.
- R2: While the requester owns the mailbox, a requester write to any of words 0 to 6 is stored on the clock edge and reads back from both ports.
- R3: While the requester owns the mailbox, a requester write to word 7 passes ownership to the responder on that edge. From then on, bit 31 of word 7 reads 1 on both ports and bits 30:0 read as written.
- R4: `handoffPulse` is high for exactly the one cycle that follows each edge on which ownership passes to the responder, and low at all other times.
- R5: While the responder owns the mailbox, requester writes to any word, word 7 included, change no stored bit and do not change ownership.
- R6: While the requester owns the mailbox, responder writes to any word change no stored bit and do not change ownership.
- R7: While the responder owns the mailbox, a responder write to word 7 stores bits 30:0 and returns ownership to the requester. A 1 written to bit 31 is dropped, so bit 31 reads 0 afterwards, and no `handoffPulse` is raised.
- R8: While `fnResetActive` is 1, `reqRdData` is 0xFFFFFFFF for every address. `rspRdData` still shows the true contents, and the contents are unchanged once the input drops.
- R9: Header fields in word 7 pass between the sides unaltered: type in bits 2:0, version in bits 5:3, direction in bit 7 (0 = request, 1 = response), status in bits 15:8 and the reset-request flag in bit 24. Only bit 31 is replaced by the owner flag.
- R10: A request may consist of the word 7 write alone. Ownership passes, and words 0 to 6 keep their earlier values.
- R11: While the responder owns the mailbox, responder writes to words 0 to 6 are stored and are visible to the requester after ownership returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fnResetActive | input | 1 | Function reset in progress; forces requester reads to all ones |
| reqWrEn | input | 1 | Requester write enable |
| reqWrAddr | input | 3 | Requester write word address |
| reqWrData | input | 32 | Requester write data |
| reqRdAddr | input | 3 | Requester read word address |
| reqRdData | output | 32 | Requester read data |
| rspWrEn | input | 1 | Responder write enable |
| rspWrAddr | input | 3 | Responder write word address |
| rspWrData | input | 32 | Responder write data |
| rspRdAddr | input | 3 | Responder read word address |
| rspRdData | output | 32 | Responder read data |
| ownedByRsp | output | 1 | 1 while the responder owns the mailbox |
| handoffPulse | output | 1 | One-cycle pulse after ownership passes to the responder |

## Verification
The assertions allow both sides to assert their write enables in the same cycle. Their only assumption is that the non-owner may write at any time and that such a write must leave the storage untouched. The ownership checks presume that the write addresses are stable at the clock edge. The stimulus changes every input on the falling edge, so each write is presented for exactly one rising edge. It also deliberately issues non-owner writes, including word 7 writes from both sides, in both ownership states.

// File: rtl/handoff_mailbox_pkg.sv
package handoff_mailbox_pkg;

  // Header field positions inside the final word (carried transparently)
  localparam int HDR_TYPE_LSB   = 0;
  localparam int HDR_VER_LSB    = 3;
  localparam int HDR_DIR_BIT    = 7;
  localparam int HDR_STATUS_LSB = 8;
  localparam int HDR_RSTREQ_BIT = 24;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrLoad;    // accepted write this cycle
    logic useRsp;    // take address/data from the responder port
    logic lastWord;  // accepted write targets the final word
  } mbxStrobe_t;

endpackage

// File: rtl/handoff_mailbox_ctrl.sv
module handoff_mailbox_ctrl
  import handoff_mailbox_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  localparam int ADDR_W = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqWrEn,
  input  logic [ADDR_W-1:0] reqWrAddr,
  input  logic              rspWrEn,
  input  logic [ADDR_W-1:0] rspWrAddr,
  output mbxStrobe_t        strobe,
  output logic              ownedByRsp,
  output logic              handoffPulse
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_WORDS - 1);

  logic ownQ;
  logic pulseQ;

  // Only the current owner's write port is honoured
  always_comb begin
    strobe.useRsp   = ownQ;
    strobe.wrLoad   = ownQ ? rspWrEn : reqWrEn;
    strobe.lastWord = ownQ ? (rspWrAddr == LAST_ADDR) : (reqWrAddr == LAST_ADDR);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ownQ   <= 1'b0;
      pulseQ <= 1'b0;
    end else begin
      pulseQ <= strobe.wrLoad && strobe.lastWord && !ownQ;
      if (strobe.wrLoad && strobe.lastWord) begin
        ownQ <= !ownQ;
      end
    end
  end

  assign ownedByRsp   = ownQ;
  assign handoffPulse = pulseQ;

  AST_REQ_LAST_GRANTS: assert property (@(posedge clk) disable iff (!rstN)
    (reqWrEn && reqWrAddr == LAST_ADDR && !ownedByRsp) |=> ownedByRsp); // R3
  AST_RSP_LAST_RETURNS: assert property (@(posedge clk) disable iff (!rstN)
    (rspWrEn && rspWrAddr == LAST_ADDR && ownedByRsp) |=> !ownedByRsp); // R7
  AST_PULSE_ON_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    handoffPulse |-> (ownedByRsp && !$past(ownedByRsp))); // R4
  AST_OWNER_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!reqWrEn && !rspWrEn) |=> $stable(ownedByRsp)); // R5
  AST_NONOWNER_RSP_NO_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    (!ownedByRsp && !reqWrEn && rspWrEn) |=> !ownedByRsp); // R6

endmodule

// File: rtl/handoff_mailbox_dp.sv
module handoff_mailbox_dp
  import handoff_mailbox_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 8,
  localparam int ADDR_W = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbxStrobe_t        strobe,
  input  logic              ownedByRsp,
  input  logic              fnResetActive,
  input  logic [ADDR_W-1:0] reqWrAddr,
  input  logic [WORD_W-1:0] reqWrData,
  input  logic [ADDR_W-1:0] rspWrAddr,
  input  logic [WORD_W-1:0] rspWrData,
  input  logic [ADDR_W-1:0] reqRdAddr,
  input  logic [ADDR_W-1:0] rspRdAddr,
  output logic [WORD_W-1:0] reqRdData,
  output logic [WORD_W-1:0] rspRdData
);

  localparam int LAST_IDX = NUM_WORDS - 1;

  logic [NUM_WORDS*WORD_W-1:0] flatStore;
  logic [ADDR_W-1:0]           wrAddr;
  logic [WORD_W-1:0]           wrData;
  logic [WORD_W-1:0]           reqView;

  always_comb begin
    wrAddr = strobe.useRsp ? rspWrAddr : reqWrAddr;
    wrData = strobe.useRsp ? rspWrData : reqWrData;
  end

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] wordQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        wordQ <= '0;
      end else if (strobe.wrLoad && wrAddr == ADDR_W'(g)) begin
        wordQ <= wrData;
      end
    end
    assign flatStore[g*WORD_W +: WORD_W] = wordQ;
  end

  // Read views: final word shows the owner flag in its top bit
  always_comb begin
    reqView = '0;
    if (int'(reqRdAddr) < NUM_WORDS) begin
      reqView = flatStore[int'(reqRdAddr)*WORD_W +: WORD_W];
      if (int'(reqRdAddr) == LAST_IDX) reqView[WORD_W-1] = ownedByRsp;
    end
    reqRdData = fnResetActive ? '1 : reqView;
  end

  always_comb begin
    rspRdData = '0;
    if (int'(rspRdAddr) < NUM_WORDS) begin
      rspRdData = flatStore[int'(rspRdAddr)*WORD_W +: WORD_W];
      if (int'(rspRdAddr) == LAST_IDX) rspRdData[WORD_W-1] = ownedByRsp;
    end
  end

  AST_NONOWNER_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (ownedByRsp && !strobe.wrLoad) |=> $stable(flatStore)); // R5
  AST_NONOWNER_RSP_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!ownedByRsp && !strobe.wrLoad) |=> $stable(flatStore)); // R6

endmodule

// File: rtl/handoff_mailbox.sv
module handoff_mailbox
  import handoff_mailbox_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 8,
  localparam int ADDR_W = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fnResetActive,
  input  logic              reqWrEn,
  input  logic [ADDR_W-1:0] reqWrAddr,
  input  logic [WORD_W-1:0] reqWrData,
  input  logic [ADDR_W-1:0] reqRdAddr,
  output logic [WORD_W-1:0] reqRdData,
  input  logic              rspWrEn,
  input  logic [ADDR_W-1:0] rspWrAddr,
  input  logic [WORD_W-1:0] rspWrData,
  input  logic [ADDR_W-1:0] rspRdAddr,
  output logic [WORD_W-1:0] rspRdData,
  output logic              ownedByRsp,
  output logic              handoffPulse
);

  mbxStrobe_t strobe;

  handoff_mailbox_ctrl #(.NUM_WORDS(NUM_WORDS)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .reqWrEn(reqWrEn), .reqWrAddr(reqWrAddr),
    .rspWrEn(rspWrEn), .rspWrAddr(rspWrAddr),
    .strobe(strobe), .ownedByRsp(ownedByRsp), .handoffPulse(handoffPulse)
  );

  handoff_mailbox_dp #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .ownedByRsp(ownedByRsp), .fnResetActive(fnResetActive),
    .reqWrAddr(reqWrAddr), .reqWrData(reqWrData),
    .rspWrAddr(rspWrAddr), .rspWrData(rspWrData),
    .reqRdAddr(reqRdAddr), .rspRdAddr(rspRdAddr),
    .reqRdData(reqRdData), .rspRdData(rspRdData)
  );

endmodule

// File: tb/handoff_mailbox_tb_top.sv
module handoff_mailbox_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fnResetActive = 1'b0;
  logic        reqWrEn = 1'b0;
  logic [2:0]  reqWrAddr = '0;
  logic [31:0] reqWrData = '0;
  logic [2:0]  reqRdAddr = '0;
  logic [31:0] reqRdData;
  logic        rspWrEn = 1'b0;
  logic [2:0]  rspWrAddr = '0;
  logic [31:0] rspWrData = '0;
  logic [2:0]  rspRdAddr = '0;
  logic [31:0] rspRdData;
  logic        ownedByRsp;
  logic        handoffPulse;

  int errors = 0;
  int checks = 0;
  logic [31:0] mdl [8];
  logic mdlOwn = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  handoff_mailbox dut_i (
    .clk(clk), .rstN(rstN), .fnResetActive(fnResetActive),
    .reqWrEn(reqWrEn), .reqWrAddr(reqWrAddr), .reqWrData(reqWrData),
    .reqRdAddr(reqRdAddr), .reqRdData(reqRdData),
    .rspWrEn(rspWrEn), .rspWrAddr(rspWrAddr), .rspWrData(rspWrData),
    .rspRdAddr(rspRdAddr), .rspRdData(rspRdData),
    .ownedByRsp(ownedByRsp), .handoffPulse(handoffPulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expWord(input int i);
    logic [31:0] w = mdl[i];
    if (i == 7) w[31] = mdlOwn;
    return w;
  endfunction

  // Read every word on both ports and compare with the model
  task automatic chkAll(input string req);
    for (int i = 0; i < 8; i++) begin
      reqRdAddr = 3'(i);
      rspRdAddr = 3'(i);
      #1;
      chk(req, reqRdData, fnResetActive ? 32'hFFFF_FFFF : expWord(i));
      chk(req, rspRdData, expWord(i));
    end
  endtask

  // One-cycle writes; the model follows the requirements
  task automatic reqWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reqWrEn = 1'b1; reqWrAddr = a; reqWrData = d;
    if (!mdlOwn) begin
      mdl[a] = d;
      if (a == 3'd7) mdlOwn = 1'b1;
    end
    @(negedge clk);
    reqWrEn = 1'b0;
  endtask

  task automatic rspWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    rspWrEn = 1'b1; rspWrAddr = a; rspWrData = d;
    if (mdlOwn) begin
      mdl[a] = d;
      if (a == 3'd7) mdlOwn = 1'b0;
    end
    @(negedge clk);
    rspWrEn = 1'b0;
  endtask

  task automatic t_reset();
    chkAll("R1");
    chk("R1 owner", 32'(ownedByRsp), 32'd0);
    chk("R1 pulse", 32'(handoffPulse), 32'd0);
  endtask

  task automatic t_payload();
    for (int i = 0; i < 7; i++) reqWrite(3'(i), 32'hA5A5_0000 + 32'(i * 17));
    chkAll("R2");
    chk("R2 owner", 32'(ownedByRsp), 32'd0);
  endtask

  task automatic t_nonOwnerRsp();
    rspWrite(3'd2, 32'hDEAD_BEEF);
    rspWrite(3'd7, 32'h8000_00FF);
    chkAll("R6");
    chk("R6 owner", 32'(ownedByRsp), 32'd0);
  endtask

  task automatic t_request();
    // type=1, version=0, direction=request, reset-request flag set (R9)
    reqWrite(3'd7, 32'h0100_0001);
    chk("R3 owner", 32'(ownedByRsp), 32'd1);
    chk("R4 pulse high", 32'(handoffPulse), 32'd1);
    chkAll("R3");
    rspRdAddr = 3'd7; #1;
    chk("R9 rsp header", rspRdData, 32'h8100_0001);
    @(negedge clk);
    chk("R4 pulse low", 32'(handoffPulse), 32'd0);
  endtask

  task automatic t_nonOwnerReq();
    reqWrite(3'd0, 32'h1234_5678);
    reqWrite(3'd7, 32'h0000_0002);
    chk("R5 owner", 32'(ownedByRsp), 32'd1);
    chk("R5 pulse", 32'(handoffPulse), 32'd0);
    chkAll("R5");
  endtask

  task automatic t_respond();
    rspWrite(3'd4, 32'hC0FF_EE00);
    // response: type=1, version=0, direction=1, status=0x03, top bit set
    rspWrite(3'd7, 32'h8000_0381);
    chk("R7 owner", 32'(ownedByRsp), 32'd0);
    chk("R7 pulse", 32'(handoffPulse), 32'd0);
    reqRdAddr = 3'd7; #1;
    chk("R9 req header", reqRdData, 32'h0000_0381);
    chkAll("R11");
  endtask

  task automatic t_fnReset();
    @(negedge clk);
    fnResetActive = 1'b1;
    chkAll("R8");
    @(negedge clk);
    fnResetActive = 1'b0;
    chkAll("R8 after");
  endtask

  task automatic t_headerOnly();
    // type=2, version=0, request, no payload written
    reqWrite(3'd7, 32'h0000_0002);
    chk("R10 owner", 32'(ownedByRsp), 32'd1);
    chk("R10 pulse", 32'(handoffPulse), 32'd1);
    chkAll("R10");
    rspWrite(3'd7, 32'h0000_0082);
    chk("R10 return", 32'(ownedByRsp), 32'd0);
    chkAll("R10 end");
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_payload();
    t_nonOwnerRsp();
    t_request();
    t_nonOwnerReq();
    t_respond();
    t_fnReset();
    t_headerOnly();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule